// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This peripheral holds two independent down counters behind a single word-addressed register window. Each counter has its own interrupt line. Software gives each counter a start value, picks periodic or one-shot operation and an interrupt enable, and then turns it on. A counter that reaches zero sets a sticky flag. In periodic operation it then reloads itself, and in one-shot operation it halts.

A new start value can be applied in two ways. The first restarts the running count at once. The second is a background update that takes effect only at the next reload, so the period can change without disturbing the interval already under way. The raw flag is cleared by writing a one to it. A masked view of the flag, gated by the interrupt enable, is what drives the interrupt pin.

The block also has a mode word that records a request to join both counters into one wide counter. The block only stores and returns that request; it does not act on it.

Top module: `dual_dcount_timer`

## Requirements
- R1: Word address map. Timer k occupies words 6k to 6k+5: the live count at +0, the reload value at +1, the background value at +2, control at +3, the raw flag at +4 and the masked flag at +5. The mode word is at word 21. Reads of any other word return 0, and every read returns 0 while `bus_rd` is low.
- R2: Control bit 0 enables counting, bit 1 selects one-shot when set, and bit 2 enables the interrupt. Control reads back in bits 2:0 with the upper bits zero.
- R3: A control write with bit 0 set loads the count from the reload value on that edge, and the count then falls by one per clock. A control write with bit 0 clear freezes the count.
- R4: On the clock where a running count is 0, the raw flag (bit 0 of +4) is set. In periodic mode the count takes the reload value on that same edge.
- R5: In one-shot mode the count stays at 0 after it expires and stops counting.
- R6: Writing 1 to raw-flag bit 0 clears the flag, and writing 0 leaves it unchanged. An expiry on the same edge as a clear wins, and the flag stays set.
- R7: The masked flag (bit 0 of +5) and `irq[k]` both equal the raw flag ANDed with control bit 2, and both follow every register write.
- R8: A write to the reload value while enabled restarts the count from the written value on that edge. While disabled, the write only stores the value.
- R9: A write to the background value updates both the background value and the reload value and leaves the live count untouched. The new value is used at the next periodic reload.
- R10: Writes to the live-count word, the masked-flag word and unmapped words have no effect.
- R11: Bit 0 of the mode word is stored and read back, with upper bits zero, and has no effect on counting.
- R12: The two timers are independent. Accesses to one never change the other.
- R13: After reset every register reads 0 and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid while high |
| bus_wr | input | 1 | Write strobe, one word per clock |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| irq | output | 2 | Per-timer interrupt, raw flag AND enable |

## Verification
The bench builds the block with its default values: two timers, 32-bit counters and the mode word at 21. With these values the full 22-word map and the holes after it fall inside the 5-bit address space. Start values of only a few counts make expiry, periodic reload and one-shot halt happen within a handful of cycles, so each reload edge can be checked exactly. Between directed steps, a behavioural model checks the read port and both interrupt lines on every clock.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  // Register slot inside one timer's six-word group.
  typedef enum logic [2:0] {
    RG_COUNT  = 3'd0,
    RG_LOAD   = 3'd1,
    RG_BGLOAD = 3'd2,
    RG_CTRL   = 3'd3,
    RG_RAW    = 3'd4,
    RG_MASKED = 3'd5
  } reg_sel_e;

  localparam int REGS_PER_TMR = 6;
  localparam int CTRL_W       = 3;

  // Packed so that bit 0 is the enable, bit 1 one-shot, bit 2 interrupt enable.
  typedef struct packed {
    logic irq_en;
    logic one_shot;
    logic run_en;
  } tmr_ctrl_t;

endpackage

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  reg_sel_e         wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] bg_o,
  output tmr_ctrl_t        ctrl_o,
  output logic             raw_o,
  output logic             irq_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] load_q, load_d;
  logic [CNT_W-1:0] bg_q, bg_d;
  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic             raw_q, raw_d;
  logic             run_q, run_d;
  logic             expire;
  logic             clr;
  logic             upd;

  // Next-state: counting first, then register writes override the count.
  always_comb begin
    cnt_d  = cnt_q;
    load_d = load_q;
    bg_d   = bg_q;
    ctrl_d = ctrl_q;
    run_d  = run_q;
    clr    = 1'b0;
    expire = run_q && (cnt_q == '0);

    if (run_q) begin
      if (expire) begin
        if (ctrl_q.one_shot) run_d = 1'b0;
        else                 cnt_d = load_q;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end

    if (wr_hit) begin
      case (wr_sel)
        RG_LOAD: begin
          load_d = wr_data;
          if (ctrl_q.run_en) begin
            cnt_d = wr_data;
            run_d = 1'b1;
          end
        end
        RG_BGLOAD: begin
          bg_d   = wr_data;
          load_d = wr_data;
        end
        RG_CTRL: begin
          ctrl_d = tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
          if (wr_data[0]) begin
            cnt_d = load_q;
            run_d = 1'b1;
          end else begin
            run_d = 1'b0;
          end
        end
        RG_RAW:  clr = wr_data[0];
        default: ;
      endcase
    end

    // An expiry on the clearing edge keeps the flag set.
    raw_d = (raw_q & ~clr) | expire;
  end

  // Registers only move on a write to this timer or while it runs.
  assign upd = wr_hit | run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
      bg_q   <= '0;
      ctrl_q <= '0;
      raw_q  <= 1'b0;
      run_q  <= 1'b0;
    end else if (upd) begin
      cnt_q  <= cnt_d;
      load_q <= load_d;
      bg_q   <= bg_d;
      ctrl_q <= ctrl_d;
      raw_q  <= raw_d;
      run_q  <= run_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = load_q;
  assign bg_o   = bg_q;
  assign ctrl_o = ctrl_q;
  assign raw_o  = raw_q;
  assign irq_o  = raw_q & ctrl_q.irq_en;

endmodule

// File: rtl/dtmr_rdmux.sv
module dtmr_rdmux
  import dtmr_pkg::*;
#(
  parameter int N_TMR    = 2,
  parameter int CNT_W    = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int MODE_IDX = 21
) (
  input  logic                          rd,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [N_TMR-1:0][CNT_W-1:0]   cnt_v,
  input  logic [N_TMR-1:0][CNT_W-1:0]   load_v,
  input  logic [N_TMR-1:0][CNT_W-1:0]   bg_v,
  input  logic [N_TMR-1:0][CTRL_W-1:0]  ctrl_v,
  input  logic [N_TMR-1:0]              raw_v,
  input  logic [N_TMR-1:0]              mis_v,
  input  logic                          mode,
  output logic [DATA_W-1:0]             rdata
);

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (int'(addr) == MODE_IDX) rdata = DATA_W'(mode);
      for (int k = 0; k < N_TMR; k++) begin
        if (int'(addr) >= k * REGS_PER_TMR && int'(addr) < (k + 1) * REGS_PER_TMR) begin
          case (reg_sel_e'(3'(int'(addr) - k * REGS_PER_TMR)))
            RG_COUNT:  rdata = DATA_W'(cnt_v[k]);
            RG_LOAD:   rdata = DATA_W'(load_v[k]);
            RG_BGLOAD: rdata = DATA_W'(bg_v[k]);
            RG_CTRL:   rdata = DATA_W'(ctrl_v[k]);
            RG_RAW:    rdata = DATA_W'(raw_v[k]);
            RG_MASKED: rdata = DATA_W'(mis_v[k]);
            default:   rdata = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/dual_dcount_timer.sv
module dual_dcount_timer
  import dtmr_pkg::*;
#(
  parameter  int N_TMR    = 2,
  parameter  int CNT_W    = 32,
  parameter  int DATA_W   = 32,
  parameter  int MODE_IDX = 21,
  localparam int ADDR_W   = $clog2(MODE_IDX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_TMR-1:0]  irq
);

  logic [N_TMR-1:0][CNT_W-1:0]  cnt_v, load_v, bg_v;
  logic [N_TMR-1:0][CTRL_W-1:0] ctrl_v;
  logic [N_TMR-1:0]             raw_v;
  logic                         mode_q, mode_d, mode_we;

  for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
    localparam int BASE = k * REGS_PER_TMR;
    logic      hit;
    reg_sel_e  sel;
    tmr_ctrl_t ctrl;

    assign hit = bus_wr && (int'(bus_addr) >= BASE) && (int'(bus_addr) < BASE + REGS_PER_TMR);
    assign sel = reg_sel_e'(3'(int'(bus_addr) - BASE));

    dtmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (hit),
      .wr_sel (sel),
      .wr_data(bus_wdata[CNT_W-1:0]),
      .cnt_o  (cnt_v[k]),
      .load_o (load_v[k]),
      .bg_o   (bg_v[k]),
      .ctrl_o (ctrl),
      .raw_o  (raw_v[k]),
      .irq_o  (irq[k])
    );

    assign ctrl_v[k] = ctrl;
  end

  // Wide-mode request word: stored only.
  assign mode_we = bus_wr && (int'(bus_addr) == MODE_IDX);
  assign mode_d  = bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_we) mode_q <= mode_d;
  end

  dtmr_rdmux #(
    .N_TMR(N_TMR), .CNT_W(CNT_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .MODE_IDX(MODE_IDX)
  ) u_rd (
    .rd    (bus_rd),
    .addr  (bus_addr),
    .cnt_v (cnt_v),
    .load_v(load_v),
    .bg_v  (bg_v),
    .ctrl_v(ctrl_v),
    .raw_v (raw_v),
    .mis_v (irq),
    .mode  (mode_q),
    .rdata (bus_rdata)
  );

endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
  parameter int N_TMR    = 2,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int MODE_IDX = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [N_TMR-1:0]  irq
);

  // R1
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);

  // R10
  hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && int'(bus_addr) >= N_TMR * 6 && int'(bus_addr) != MODE_IDX) |-> bus_rdata == '0);

  // R11
  mode_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && int'(bus_addr) == MODE_IDX) |-> bus_rdata[DATA_W-1:1] == '0);

  for (genvar k = 0; k < N_TMR; k++) begin : g_k
    // R2
    ctrl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && int'(bus_addr) == k * 6 + 3) |-> bus_rdata[DATA_W-1:3] == '0);

    // R6
    raw_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && int'(bus_addr) == k * 6 + 4) |-> bus_rdata[DATA_W-1:1] == '0);

    // R7
    mis_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && int'(bus_addr) == k * 6 + 5) |-> bus_rdata == DATA_W'(irq[k]));

    // R6
    irq_fall_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[k]) |-> $past(bus_wr));
  end

endmodule

bind dual_dcount_timer dtmr_chk #(
  .N_TMR(N_TMR), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_IDX(MODE_IDX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .irq      (irq)
);

// File: tb/dual_dcount_timer_test.sv
module dual_dcount_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b1;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_dcount_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Behavioural reference model.
  logic [31:0] m_cnt[2], m_load[2], m_bg[2], m_ctrl[2];
  bit          m_raw[2], m_run[2];
  bit          m_mode;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_cnt[k] = 0; m_load[k] = 0; m_bg[k] = 0; m_ctrl[k] = 0;
        m_raw[k] = 0; m_run[k] = 0;
      end
      m_mode = 0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        bit ex, clr;
        int rel;
        ex  = m_run[k] && (m_cnt[k] == 0);
        clr = 0;
        if (m_run[k]) begin
          if (ex) begin
            if (m_ctrl[k][1]) m_run[k] = 0;
            else              m_cnt[k] = m_load[k];
          end else m_cnt[k] = m_cnt[k] - 1;
        end
        rel = int'(bus_addr) - 6 * k;
        if (bus_wr && rel >= 0 && rel < 6) begin
          if (rel == 1) begin
            m_load[k] = bus_wdata;
            if (m_ctrl[k][0]) begin m_cnt[k] = bus_wdata; m_run[k] = 1; end
          end else if (rel == 2) begin
            m_bg[k] = bus_wdata; m_load[k] = bus_wdata;
          end else if (rel == 3) begin
            m_ctrl[k] = bus_wdata & 32'h7;
            if (bus_wdata[0]) begin m_cnt[k] = m_load[k]; m_run[k] = 1; end
            else m_run[k] = 0;
          end else if (rel == 4) clr = bus_wdata[0];
        end
        m_raw[k] = (m_raw[k] && !clr) || ex;
      end
      if (bus_wr && bus_addr == 5'd21) m_mode = bus_wdata[0];
    end
  end

  function automatic logic [31:0] m_read(input int a, input bit rd);
    int k, rel;
    if (!rd) return 0;
    if (a == 21) return {31'b0, m_mode};
    if (a >= 12) return 0;
    k = a / 6; rel = a % 6;
    case (rel)
      0: return m_cnt[k];
      1: return m_load[k];
      2: return m_bg[k];
      3: return m_ctrl[k];
      4: return {31'b0, m_raw[k]};
      default: return {31'b0, m_raw[k] & m_ctrl[k][2]};
    endcase
  endfunction

  function automatic logic [1:0] m_irq();
    return {m_raw[1] & m_ctrl[1][2], m_raw[0] & m_ctrl[0][2]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model, then inputs may change.
  task automatic cmp();
    @(negedge clk);
    if (rst_n) begin
      chk("R7 irq vs model", {30'b0, irq}, {30'b0, m_irq()});
      chk("R1 rdata vs model", bus_rdata, m_read(int'(bus_addr), bus_rd));
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cmp();
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
  endtask

  task automatic peek(input int a, output logic [31:0] v);
    cmp();
    bus_wr = 1'b0; bus_addr = 5'(a);
    #1 v = bus_rdata;
  endtask

  task automatic expect_rd(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] v;
    peek(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R13 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v1, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state across the whole address space
    for (int a = 0; a < 32; a++) expect_rd("R13 reset read", a, 0);
    chk("R13 reset irq", {30'b0, irq}, 0);

    // R2 control bit mapping and width
    wr(3, 32'hFFFF_FFF8);
    expect_rd("R2 ctrl upper bits dropped", 3, 0);
    wr(3, 32'h0000_000A);
    expect_rd("R2 ctrl oneshot bit", 3, 32'h2);
    wr(3, 0);

    // R9 background value while disabled
    wr(2, 100);
    expect_rd("R9 bg stored", 2, 100);
    expect_rd("R9 load follows bg", 1, 100);
    expect_rd("R9 count untouched", 0, 0);

    // R3 / R4 periodic run with load 3
    wr(2, 3);
    wr(3, 1);
    expect_rd("R3 count loaded", 0, 3);
    expect_rd("R3 count step", 0, 2);
    expect_rd("R3 count step", 0, 1);
    expect_rd("R4 count zero", 0, 0);
    expect_rd("R4 periodic reload", 0, 3);
    expect_rd("R4 count after reload", 0, 2);
    expect_rd("R4 raw set", 4, 1);

    // R3 freeze
    wr(3, 0);
    peek(0, v1);
    peek(0, v2);
    chk("R3 frozen count", v2, v1);

    // R6 write-one-to-clear
    wr(4, 0);
    expect_rd("R6 write zero keeps flag", 4, 1);
    // R7 enable interrupt with flag pending
    wr(3, 4);
    expect_rd("R7 masked flag", 5, 1);
    chk("R7 irq pin", {30'b0, irq}, 32'h1);
    wr(4, 1);
    expect_rd("R6 flag cleared", 4, 0);
    chk("R7 irq drops", {30'b0, irq}, 0);

    // R5 one-shot
    wr(2, 2);
    wr(3, 7);
    expect_rd("R5 count 2", 0, 2);
    expect_rd("R5 count 1", 0, 1);
    expect_rd("R5 count 0", 0, 0);
    expect_rd("R5 held at 0", 0, 0);
    expect_rd("R5 still 0", 0, 0);
    expect_rd("R5 raw set", 4, 1);
    chk("R5 irq set", {30'b0, irq}, 32'h1);
    wr(4, 1);

    // R8 reload write while disabled then enabled
    wr(3, 0);
    peek(0, v1);
    wr(1, 5);
    expect_rd("R8 disabled count kept", 0, v1);
    expect_rd("R8 load stored", 1, 5);
    wr(3, 1);
    wr(2, 2);
    // R9 background update during a run
    expect_rd("R9 run not restarted", 0, 4);
    expect_rd("R9 count", 0, 3);
    expect_rd("R9 count", 0, 2);
    expect_rd("R9 count", 0, 1);
    expect_rd("R9 count", 0, 0);
    expect_rd("R9 new period on reload", 0, 2);
    wr(1, 50);
    expect_rd("R8 enabled restart", 0, 50);
    expect_rd("R8 counting on", 0, 49);

    // R6 expiry on the clearing edge: count 0 on the edge of the clear
    wr(3, 0);
    wr(4, 1);
    wr(1, 1);
    wr(3, 1);
    // count=1 now; next edge -> 0, following edge expires
    cmp(); bus_wr = 1'b0;
    wr(4, 1);
    expect_rd("R6 set wins over clear", 4, 1);

    // R10 ignored writes
    wr(3, 0);
    peek(0, v1);
    wr(0, 32'h1234);
    expect_rd("R10 count write ignored", 0, v1);
    wr(5, 32'hFFFF_FFFF);
    expect_rd("R10 masked write ignored", 4, 1);
    wr(15, 32'hDEAD_BEEF);
    expect_rd("R10 hole reads zero", 15, 0);
    expect_rd("R10 timer0 load unchanged", 1, 1);

    // R11 mode word
    wr(21, 32'hFFFF_FFFF);
    expect_rd("R11 mode stored", 21, 1);
    wr(2, 3);
    wr(3, 1);
    expect_rd("R11 counting unaffected", 0, 3);
    wr(21, 0);
    expect_rd("R11 mode cleared", 21, 0);
    wr(3, 0);

    // R12 second timer independent
    peek(0, v1);
    wr(8, 4);
    wr(9, 7);
    expect_rd("R12 timer1 count", 6, 4);
    expect_rd("R12 timer0 untouched", 0, v1);
    expect_rd("R12 timer0 load", 1, 3);
    repeat (8) cmp();
    expect_rd("R12 timer1 raw", 10, 1);
    chk("R12 irq lines", {30'b0, irq}, 32'h2);

    // R1 read strobe low
    cmp(); bus_rd = 1'b0; bus_addr = 5'd8;
    #1 chk("R1 idle read zero", bus_rdata, 0);
    repeat (4) cmp();
    bus_rd = 1'b1;
    repeat (4) cmp();

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule